// File: doc/BRIEF.md
# Banked Memory Map Address Decoder

This block sits between an 8-bit microcontroller's demultiplexed 16-bit external address bus and the devices behind it. It sorts every strobed access into one of several address regions. It drives the chip enable and the upper physical address bits of a large external SRAM, pulls one of sixteen active-low peripheral selects low, and raises a wait request when the access falls in the slow peripheral area.

The lower half of the CPU space reaches SRAM one-to-one. The next 16 KB is a window into SRAM whose upper address bits come from a bank number register. Software loads that register by writing to a reserved 256-byte page inside the fast peripheral space. A single enable bit in the same page makes a 4 KB area above the window reach the bottom of physical SRAM. The CPU's on-chip memory otherwise hides that part of SRAM. Everything from 0xD000 up is peripheral space. Its lower 4 KB needs no extra wait. The top 8 KB holds the strobe in wait for a set number of clocks.

Top module: `banked_map_decoder`

## Requirements
- R1: With rd_n and wr_n both high, sram_ce_n and all sixteen io_cs_n lines are high, wait_req is low, and sram_addr_hi is zero.
- R2: A strobed access to an address below 0x1100, which the CPU serves internally, asserts no select.
- R3: A strobed access to 0x1100–0x7FFF drives sram_ce_n low with physical address equal to the CPU address, so sram_addr_hi equals address bits 15:8.
- R4: A strobed access to 0x8000–0xBFFF drives sram_ce_n low with physical address bank × 0x4000 + (address − 0x8000). sram_addr_hi carries physical bits 21:8, with the bank number in bits 13:6 and address bits 13:8 below it.
- R5: A write to any address 0xD000–0xD0FE loads data bits 7:0 into the bank number. The load happens on the rising edge of wr_n, so the new bank applies from the next access on.
- R6: A write to 0xD0FF loads data bit 0 into the remap enable and leaves the bank number unchanged.
- R7: With the remap enable set, a strobed access to 0xC000–0xCFFF drives sram_ce_n low at physical address (address − 0xC000). With it clear, that range selects nothing.
- R8: A strobed access to 0xD100–0xFFFF drives io_cs_n[address bits 15:12] low, and only that line. An access to the bank page 0xD000–0xD0FF asserts no peripheral select.
- R9: A strobed access to 0xE000–0xFFFF holds wait_req high for the first WAIT_CYCLES clocks of the strobe and low after that. Accesses in 0xD000–0xDFFF never raise it.
- R10: After reset the bank number is 0 and the remap enable is 0.
- R11: In any cycle at most one of sram_ce_n and the sixteen io_cs_n lines is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Demultiplexed CPU address |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| data_in | input | 8 | CPU data bus, sampled for register writes |
| sram_ce_n | output | 1 | Active-low SRAM chip enable |
| sram_addr_hi | output | 14 | Physical SRAM address bits 21:8 |
| io_cs_n | output | 16 | Active-low peripheral selects, one per 4 KB of CPU space |
| wait_req | output | 1 | Wait request for slow peripheral accesses |

## Verification
The bench builds the block with its defaults: an 8-bit bank number, a 14-bit window offset and a two-clock slow-region wait. An 8-bit bank lets the bench reach the all-ones bank, which fills the top physical address bits. A two-clock wait is short enough to see the whole assert-then-release sequence, and the restart on a later strobe, within one read. The reference model also follows the bank page boundary, 0xD0FF against the rest of the page, and the order of bank load and next access.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

  // Address region classes produced by the region decoder
  typedef enum logic [2:0] {
    RG_NONE    = 3'd0,
    RG_LINEAR  = 3'd1,
    RG_BANKED  = 3'd2,
    RG_REMAP   = 3'd3,
    RG_REGPAGE = 3'd4,
    RG_IO_FAST = 3'd5,
    RG_IO_SLOW = 3'd6
  } region_e;

endpackage

// File: rtl/bmd_reset_sync.sv
module bmd_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/bmd_region_decode.sv
module bmd_region_decode
  import bmd_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          PAGE_W     = 8,
  parameter logic [15:0] INT_TOP    = 16'h1100,
  parameter logic [15:0] BANK_BASE  = 16'h8000,
  parameter logic [15:0] REMAP_BASE = 16'hC000,
  parameter logic [15:0] IO_BASE    = 16'hD000,
  parameter logic [15:0] SLOW_BASE  = 16'hE000,
  parameter logic [15:0] REG_PAGE   = 16'hD000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              remap_en,
  output region_e           region
);

  localparam int PAGE_HI_W = ADDR_W - PAGE_W;

  logic page_hit;

  assign page_hit = (addr[ADDR_W-1:PAGE_W] == REG_PAGE[ADDR_W-1:PAGE_W]);

  always_comb begin
    region = RG_NONE;
    if (addr < INT_TOP) begin
      region = RG_NONE;
    end else if (addr < BANK_BASE) begin
      region = RG_LINEAR;
    end else if (addr < REMAP_BASE) begin
      region = RG_BANKED;
    end else if (addr < IO_BASE) begin
      region = remap_en ? RG_REMAP : RG_NONE;
    end else if (page_hit) begin
      region = RG_REGPAGE;
    end else if (addr < SLOW_BASE) begin
      region = RG_IO_FAST;
    end else begin
      region = RG_IO_SLOW;
    end
  end

endmodule

// File: rtl/bmd_bank_regs.sv
module bmd_bank_regs #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int          BANK_W   = 8,
  parameter int          PAGE_W   = 8,
  parameter logic [15:0] REG_PAGE = 16'hD000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] data_in,
  output logic [BANK_W-1:0] bank,
  output logic              remap_en
);

  localparam logic [PAGE_W-1:0] CTRL_OFFS = {PAGE_W{1'b1}};

  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic              remap_q, remap_d;
  logic              commit;
  logic              page_q;
  logic              ctrl_q;

  // Strobe and bus sampling; a commit is the rising edge of wr_n
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b1;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      wr_q   <= wr_n;
      addr_q <= addr;
      data_q <= data_in;
    end
  end

  assign commit = !wr_q && wr_n;
  assign page_q = (addr_q[ADDR_W-1:PAGE_W] == REG_PAGE[ADDR_W-1:PAGE_W]);
  assign ctrl_q = (addr_q[PAGE_W-1:0] == CTRL_OFFS);

  always_comb begin
    bank_d  = bank_q;
    remap_d = remap_q;
    if (commit && page_q) begin
      if (ctrl_q) begin
        remap_d = data_q[0];
      end else begin
        bank_d = data_q[BANK_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q  <= '0;
      remap_q <= 1'b0;
    end else begin
      bank_q  <= bank_d;
      remap_q <= remap_d;
    end
  end

  assign bank     = bank_q;
  assign remap_en = remap_q;

endmodule

// File: rtl/bmd_wait_gen.sv
module bmd_wait_gen #(
  parameter int WAIT_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_act,
  output logic wait_o
);

  localparam int CNT_W = $clog2(WAIT_CYCLES + 2);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(WAIT_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_lim;

  assign at_lim = (cnt_q == CNT_LIM);

  always_comb begin
    cnt_d = '0;
    if (slow_act) begin
      cnt_d = at_lim ? cnt_q : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign wait_o = slow_act && !at_lim;

endmodule

// File: rtl/banked_map_decoder.sv
module banked_map_decoder
  import bmd_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          BANK_W      = 8,
  parameter int          WAIT_CYCLES = 2,
  parameter logic [15:0] INT_TOP     = 16'h1100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic [7:0]  data_in,
  output logic        sram_ce_n,
  output logic [13:0] sram_addr_hi,
  output logic [15:0] io_cs_n,
  output logic        wait_req
);

  localparam int ADDR_W   = 16;
  localparam int LOW_W    = 8;
  localparam int WIN_W    = 14;
  localparam int REMAP_W  = 12;
  localparam int PHYS_W   = WIN_W + BANK_W;
  localparam int HI_W     = PHYS_W - LOW_W;
  localparam int NUM_CS   = 16;
  localparam int CS_SEL_W = $clog2(NUM_CS);

  logic              rst_sync_n;
  logic [BANK_W-1:0] bank_q;
  logic              remap_q;
  region_e           region;
  logic              strobe;
  logic              sram_hit;
  logic              io_hit;
  logic              slow_act;
  logic [PHYS_W-1:0] phys;
  logic [DATA_W-1:0] data_w;

  assign data_w = DATA_W'(data_in);

  bmd_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bmd_region_decode #(
    .ADDR_W (ADDR_W),
    .PAGE_W (LOW_W)
  ) u_dec (
    .addr     (addr),
    .remap_en (remap_q),
    .region   (region)
  );

  bmd_bank_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BANK_W (BANK_W),
    .PAGE_W (LOW_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .addr     (addr),
    .wr_n     (wr_n),
    .data_in  (data_w),
    .bank     (bank_q),
    .remap_en (remap_q)
  );

  assign strobe   = !rd_n || !wr_n;
  assign sram_hit = strobe && (region == RG_LINEAR || region == RG_BANKED ||
                               region == RG_REMAP);
  assign io_hit   = strobe && (region == RG_IO_FAST || region == RG_IO_SLOW);
  assign slow_act = strobe && (region == RG_IO_SLOW);

  bmd_wait_gen #(
    .WAIT_CYCLES (WAIT_CYCLES)
  ) u_wait (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .slow_act (slow_act),
    .wait_o   (wait_req)
  );

  // Physical SRAM address for each SRAM region
  always_comb begin
    phys = '0;
    unique case (region)
      RG_LINEAR: phys = PHYS_W'(addr);
      RG_BANKED: phys = {bank_q, addr[WIN_W-1:0]};
      RG_REMAP:  phys = PHYS_W'(addr[REMAP_W-1:0]);
      default:   phys = '0;
    endcase
  end

  assign sram_ce_n    = !sram_hit;
  assign sram_addr_hi = sram_hit ? phys[PHYS_W-1:LOW_W] : '0;

  // One select line per 4 KB slice of CPU space
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign io_cs_n[g] = !(io_hit &&
                         (addr[ADDR_W-1 -: CS_SEL_W] == CS_SEL_W'(g)));
  end

  if (HI_W != 14) begin : g_width_guard
    initial $error("bank width must give a 14-bit upper address");
  end

endmodule

// File: rtl/bmd_checker.sv
module bmd_checker #(
  parameter int WAIT_CYCLES = 2
) (
  input logic        clk,
  input logic        rst_sync_n,
  input logic [15:0] addr,
  input logic        rd_n,
  input logic        wr_n,
  input logic        sram_ce_n,
  input logic [15:0] io_cs_n,
  input logic        wait_req,
  input logic [7:0]  bank_q,
  input logic        remap_q
);

  logic [15:0] run_cnt;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_cnt <= '0;
    end else if (wait_req) begin
      run_cnt <= (run_cnt == 16'hFFFF) ? run_cnt : run_cnt + 1'b1;
    end else begin
      run_cnt <= '0;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_n && wr_n) |-> (sram_ce_n && (&io_cs_n) && !wait_req));

  // R11
  single_select_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones({~sram_ce_n, ~io_cs_n}) <= 1);

  // R9
  wait_region_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wait_req |-> (addr >= 16'hE000 && !io_cs_n[addr[15:12]]));

  // R9
  wait_release_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wait_req |-> (run_cnt < 16'(WAIT_CYCLES)));

  // R5
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(bank_q) |-> !$past(wr_n, 2));

  // R7
  remap_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!remap_q && addr >= 16'hC000 && addr < 16'hD000) |-> sram_ce_n);

  // R2
  internal_hidden_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr < 16'h1100) |-> (sram_ce_n && (&io_cs_n)));

endmodule

bind banked_map_decoder bmd_checker #(
  .WAIT_CYCLES (WAIT_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .addr       (addr),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .sram_ce_n  (sram_ce_n),
  .io_cs_n    (io_cs_n),
  .wait_req   (wait_req),
  .bank_q     (bank_q),
  .remap_q    (remap_q)
);

// File: tb/banked_map_decoder_bench.sv
`timescale 1ns/1ps
module banked_map_decoder_bench;

  localparam int WAITN = 2;

  logic        clk;
  logic        rst_n;
  logic [15:0] addr;
  logic        rd_n;
  logic        wr_n;
  logic [7:0]  data_in;
  logic        sram_ce_n;
  logic [13:0] sram_addr_hi;
  logic [15:0] io_cs_n;
  logic        wait_req;

  int checks;
  int errors;
  int cycles;
  bit done;

  // reference model state
  int m_bank;
  int m_remap;
  int m_wcnt;
  int m_prev_wr;
  int m_prev_addr;
  int m_prev_data;

  banked_map_decoder u_banked_map_decoder (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (addr),
    .rd_n         (rd_n),
    .wr_n         (wr_n),
    .data_in      (data_in),
    .sram_ce_n    (sram_ce_n),
    .sram_addr_hi (sram_addr_hi),
    .io_cs_n      (io_cs_n),
    .wait_req     (wait_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic compare(input string tag);
    int a;
    bit strobe;
    bit e_ce;
    int e_hi;
    logic [15:0] e_cs;
    bit e_wait;
    a = int'(addr);
    strobe = !rd_n || !wr_n;
    e_ce = 1'b1; e_hi = 0; e_cs = 16'hFFFF; e_wait = 1'b0;
    if (strobe) begin
      if (a < 'h1100) begin
      end else if (a < 'h8000) begin
        e_ce = 1'b0; e_hi = a / 256;
      end else if (a < 'hC000) begin
        e_ce = 1'b0; e_hi = (m_bank * 16384 + (a - 'h8000)) / 256;
      end else if (a < 'hD000) begin
        if (m_remap != 0) begin
          e_ce = 1'b0; e_hi = (a - 'hC000) / 256;
        end
      end else if (a / 256 == 'hD0) begin
      end else begin
        e_cs[a / 4096] = 1'b0;
        e_wait = (a >= 'hE000) && (m_wcnt < WAITN);
      end
    end
    checks = checks + 1;
    if (sram_ce_n !== e_ce || int'(sram_addr_hi) != e_hi ||
        io_cs_n !== e_cs || wait_req !== e_wait) begin
      errors = errors + 1;
      $display("FAIL %s addr=%h: actual ce=%b hi=%h cs=%h wait=%b expected ce=%b hi=%h cs=%h wait=%b",
               tag, addr, sram_ce_n, sram_addr_hi, io_cs_n, wait_req,
               e_ce, e_hi[13:0], e_cs, e_wait);
    end
  endtask

  task automatic model_update();
    int a;
    bit strobe;
    a = int'(addr);
    strobe = !rd_n || !wr_n;
    if (m_prev_wr == 0 && wr_n == 1'b1 && m_prev_addr / 256 == 'hD0) begin
      if (m_prev_addr % 256 == 'hFF) m_remap = m_prev_data % 2;
      else m_bank = m_prev_data;
    end
    if (strobe && a >= 'hE000) m_wcnt = (m_wcnt < WAITN) ? m_wcnt + 1 : WAITN;
    else m_wcnt = 0;
    m_prev_wr   = int'(wr_n);
    m_prev_addr = a;
    m_prev_data = int'(data_in);
  endtask

  task automatic step(input logic [15:0] a, input logic r, input logic w,
                      input logic [7:0] d, input string tag);
    @(negedge clk);
    addr = a; rd_n = r; wr_n = w; data_in = d;
    #1;
    compare(tag);
    @(posedge clk);
    #0.1;
    model_update();
  endtask

  task automatic rd(input logic [15:0] a, input int n, input string tag);
    for (int i = 0; i < n; i++) step(a, 1'b0, 1'b1, 8'h00, tag);
    step(a, 1'b1, 1'b1, 8'h00, tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    step(a, 1'b1, 1'b0, d, tag);
    step(a, 1'b1, 1'b0, d, tag);
    step(a, 1'b1, 1'b1, d, tag);
    step(16'h0000, 1'b1, 1'b1, 8'h00, tag);
  endtask

  initial begin
    checks = 0; errors = 0; cycles = 0; done = 1'b0;
    m_bank = 0; m_remap = 0; m_wcnt = 0;
    m_prev_wr = 1; m_prev_addr = 0; m_prev_data = 0;
    rst_n = 1'b0; addr = 16'h0000; rd_n = 1'b1; wr_n = 1'b1; data_in = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 idle outputs, R10 reset state seen through window and remap range
    step(16'h9000, 1'b1, 1'b1, 8'h00, "R1");
    rd(16'h8123, 1, "R10");
    rd(16'hC200, 1, "R10");

    // R2 internal region
    rd(16'h0000, 1, "R2");
    rd(16'h10FF, 1, "R2");

    // R3 linear
    rd(16'h1100, 1, "R3");
    rd(16'h7FFF, 2, "R3");
    step(16'h3456, 1'b1, 1'b0, 8'h55, "R3");
    step(16'h3456, 1'b1, 1'b1, 8'h55, "R3");

    // R5 bank load, then R4 window
    wr(16'hD012, 8'h2A, "R5");
    rd(16'h9234, 1, "R4");
    rd(16'hBFFF, 1, "R4");
    wr(16'hD0FE, 8'hFF, "R5");
    rd(16'h8000, 1, "R4");
    rd(16'hBF00, 1, "R4");

    // R7 remap off, R6 remap on via control address
    rd(16'hC123, 1, "R7");
    wr(16'hD0FF, 8'h01, "R6");
    rd(16'hC123, 1, "R7");
    rd(16'hCFFF, 1, "R7");
    rd(16'hA000, 1, "R6");
    wr(16'hD0FF, 8'h00, "R6");
    rd(16'hC800, 1, "R7");
    rd(16'h8800, 1, "R6");

    // R8 peripheral selects and register page
    rd(16'hD0FF, 1, "R8");
    rd(16'hD100, 1, "R8");
    rd(16'hDFFF, 2, "R8");
    step(16'hF000, 1'b1, 1'b0, 8'h11, "R8");
    step(16'hF000, 1'b1, 1'b1, 8'h11, "R8");

    // R9 wait request in slow region, restart on a new strobe
    rd(16'hE800, 4, "R9");
    rd(16'hFF00, 3, "R9");
    step(16'hE000, 1'b1, 1'b0, 8'h00, "R9");
    step(16'hE000, 1'b1, 1'b0, 8'h00, "R9");
    step(16'hE000, 1'b1, 1'b0, 8'h00, "R9");
    step(16'hE000, 1'b1, 1'b1, 8'h00, "R9");

    // R11 single select across a region sweep
    for (int k = 0; k < 16; k++) rd(16'(k * 4096 + 16'h0180), 1, "R11");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule